// File: doc/BRIEF.md
# Pattern-Locked Word Aligner

This block takes a parallel word stream whose word boundary is unknown and finds where the real words begin. Every cycle it compares the programmed alignment pattern against all possible bit offsets of the stream. The first time the pattern appears after reset, the block fixes the word boundary at that offset and re-frames all later data to it. Serial order is LSB first: bit 0 of an input word arrived before bit 1, and bit W-1 of one word comes just before bit 0 of the next.

At offset k, the re-framed word is built from two input words. Its low k bits are the top k bits of the previous input word. Its upper W-k bits are the low W-k bits of the current input word. In other words, offset k moves the word boundary k bits earlier in the stream.

Once locked, the block stays at its boundary. It ignores the pattern wherever else it turns up. Software or a link-level controller can force a new search with a fresh rising edge on the align-enable input. The parallel width W may be 8, 10, 16 or 20 bits.

Top module: `word_lock_aligner`

## Requirements
- R1: While rst_ni is low, data_o, pat_det_o and sync_o are all zero.
- R2: Until the first lock after reset, data_o equals the input word of the previous cycle, which is offset 0.
- R3: After reset, the block locks at the first cycle in which the pattern matches at any offset, whatever the level of align_en_i. In the cycle where data_o first carries the pattern, pat_det_o and sync_o are both high.
- R4: If the pattern matches at several offsets in the same searching cycle, the lowest offset is the one locked.
- R5: After a lock, data_o is the word at the locked offset, one cycle after the input word that completes it.
- R6: While locked, a pattern found at any other offset causes no pat_det_o pulse and does not change the offset used for data_o. This holds even while align_en_i is held high.
- R7: While locked, pat_det_o is high for exactly one cycle each time data_o carries the pattern at the locked offset.
- R8: sync_o stays high from a lock until the cycle after a 0-to-1 transition of align_en_i is sampled. It then reads zero until the next lock.
- R9: A 0-to-1 transition of align_en_i re-arms the search. The next pattern match locks to its offset, including offsets 0 and W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Incoming parallel word, LSB first in serial order |
| pattern_i | input | W | Alignment pattern to search for |
| align_en_i | input | 1 | Rising edge re-arms the boundary search |
| data_o | output | W | Re-framed word at the chosen offset |
| pat_det_o | output | 1 | One-cycle pulse when the pattern is seen at the locked offset |
| sync_o | output | 1 | High from a lock until the next re-arm edge |

## Verification
A wrong stored offset shows up on data_o in the very next cycle. The bench compares data_o against a word it rebuilds from its own copy of the serial stream at the offset the scenario expects. A stuck or wrongly cleared arm flag shows in one of two ways. Either a pattern placed at a foreign offset yields a pat_det_o pulse and a moved boundary, or a pattern placed after a re-arm edge yields no lock. Both are visible within one cycle of the planted word. An error in the edge detector shows on sync_o one cycle after align_en_i rises.

// File: rtl/wla_pkg.sv
package wla_pkg;
  // index of the lowest set bit; 0 when none is set
  function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/wla_window.sv
module wla_window #(
  parameter int unsigned W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        data_i,
  input  logic [W-1:0]        pattern_i,
  output logic [W-1:0][W-1:0] slices_o,
  output logic [W-1:0]        match_o
);
  logic [W-1:0]   prev_q;
  logic [2*W-1:0] win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  assign win = {data_i, prev_q};

  // offset k: boundary moved k bits earlier in the serial stream
  for (genvar k = 0; k < W; k++) begin : g_off
    assign slices_o[k] = win[W-k +: W];
    assign match_o[k]  = (slices_o[k] == pattern_i);
  end
endmodule

// File: rtl/wla_lock_ctrl.sv
module wla_lock_ctrl
  import wla_pkg::*;
#(
  parameter int unsigned W  = 10,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          align_en_i,
  input  logic [W-1:0]  match_i,
  output logic [OW-1:0] sel_o,
  output logic          pat_det_o,
  output logic          sync_o
);
  logic          en_q, armed_q, det_q, sync_q;
  logic [OW-1:0] off_q, first;
  logic          rise, armed_eff, hit, take;

  assign rise      = align_en_i & ~en_q;
  assign armed_eff = armed_q | rise;
  assign hit       = |match_i;
  assign take      = armed_eff & hit;
  assign first     = OW'(lowest_set(32'(match_i), W));
  assign sel_o     = take ? first : off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      armed_q <= 1'b1;
      off_q   <= '0;
      det_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      en_q <= align_en_i;
      if (take) begin
        off_q   <= first;
        armed_q <= 1'b0;
        sync_q  <= 1'b1;
        det_q   <= 1'b1;
      end else begin
        if (rise) begin
          armed_q <= 1'b1;
          sync_q  <= 1'b0;
        end
        det_q <= ~armed_eff & match_i[off_q];
      end
    end
  end

  assign pat_det_o = det_q;
  assign sync_o    = sync_q;

  // R6
  offset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !rise) |=> $stable(off_q));
  // R8
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !hit) |=> !sync_o);
  // R3
  lock_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> pat_det_o);
  // R4
  lowest_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> ((match_i & ~({W{1'b1}} << first)) == '0));
endmodule

// File: rtl/wla_out_mux.sv
module wla_out_mux #(
  parameter int unsigned W  = 10,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0][W-1:0] slices_i,
  input  logic [OW-1:0]       sel_i,
  output logic [W-1:0]        data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= slices_i[sel_i];
  end
endmodule

// File: rtl/word_lock_aligner.sv
module word_lock_aligner #(
  parameter int unsigned W  = 10,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pattern_i,
  input  logic         align_en_i,
  output logic [W-1:0] data_o,
  output logic         pat_det_o,
  output logic         sync_o
);
  if (W != 8 && W != 10 && W != 16 && W != 20) begin : g_bad_w
    $error("word_lock_aligner: W must be 8, 10, 16 or 20");
  end

  logic [W-1:0][W-1:0] slices;
  logic [W-1:0]        match;
  logic [OW-1:0]       sel;

  wla_window #(.W(W)) u_window (
    .clk_i, .rst_ni, .data_i, .pattern_i,
    .slices_o(slices), .match_o(match)
  );

  wla_lock_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni, .align_en_i,
    .match_i(match), .sel_o(sel), .pat_det_o, .sync_o
  );

  wla_out_mux #(.W(W)) u_mux (
    .clk_i, .rst_ni, .slices_i(slices), .sel_i(sel), .data_o
  );

  // R7
  det_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_det_o |-> (data_o == $past(pattern_i)));
endmodule

// File: tb/word_lock_aligner_test.sv
module word_lock_aligner_test;
  localparam int W  = 10;
  localparam int NB = 64 * W;
  localparam logic [W-1:0] PAT = 10'h305;

  logic clk = 1'b0, rst_ni = 1'b0, align_en = 1'b0;
  logic [W-1:0] data_i = '0, pattern = PAT;
  logic [W-1:0] data_o;
  logic pat_det, sync;

  int checks = 0, fails = 0, t = 0;
  bit stream [NB];
  bit done = 0;

  always #2 clk = ~clk;

  word_lock_aligner #(.W(W)) uut (
    .clk_i(clk), .rst_ni, .data_i, .pattern_i(pattern), .align_en_i(align_en),
    .data_o, .pat_det_o(pat_det), .sync_o(sync)
  );

  function automatic logic [W-1:0] slice(int tt, int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int p = tt * W - k + i;
      r[i] = (p < 0 || p >= NB) ? 1'b0 : stream[p];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0d: actual %h expected %h", req, t, act, exp);
    end
  endtask

  task automatic clear_stream();
    for (int i = 0; i < NB; i++) stream[i] = 1'b0;
  endtask

  task automatic put(int tt, int k, logic [W-1:0] p);
    for (int i = 0; i < W; i++) stream[tt * W - k + i] = p[i];
  endtask

  // drive word t at negedge, sample after posedge
  task automatic step();
    @(negedge clk);
    data_i = slice(t, 0);
    @(posedge clk);
    #1;
    t++;
  endtask

  task automatic do_reset(logic en);
    @(negedge clk);
    rst_ni = 1'b0; align_en = en; data_i = '0; t = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 data", data_o, '0);
    chk("R1 det", W'(pat_det), '0);
    chk("R1 sync", W'(sync), '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_first_lock();
    pattern = PAT;
    clear_stream();
    for (int i = 0; i < 6 * W; i++) stream[i] = (i % 3 == 1);
    stream[59] = 1'b0; stream[58] = 1'b0; stream[57] = 1'b0;
    stream[56] = 1'b0; stream[55] = 1'b0;
    put(6, 3, PAT);
    do_reset(1'b0);
    for (int c = 0; c < 6; c++) begin
      step();
      chk("R2 data", data_o, slice(t - 1, 0));
      chk("R3 nodet", W'(pat_det), '0);
    end
    step();
    chk("R3 data", data_o, PAT);
    chk("R3 det", W'(pat_det), 1);
    chk("R3 sync", W'(sync), 1);
    step();
    chk("R7 pulse", W'(pat_det), 0);
    chk("R8 hold", W'(sync), 1);
    chk("R5 data", data_o, slice(t - 1, 3));
  endtask

  task automatic t_ignore_other();
    put(12, 7, PAT);
    put(15, 3, PAT);
    while (t < 12) step();
    step();
    chk("R6 nodet", W'(pat_det), 0);
    chk("R6 offset", data_o, slice(12, 3));
    chk("R8 hold", W'(sync), 1);
    while (t < 16) step();
    chk("R7 det", W'(pat_det), 1);
    chk("R7 data", data_o, PAT);
    step();
    chk("R7 pulse", W'(pat_det), 0);
  endtask

  task automatic t_rearm();
    put(21, 9, PAT);
    put(25, 2, PAT);
    put(29, 0, PAT);
    while (t < 18) step();
    align_en = 1'b1;
    step();
    chk("R8 clear", W'(sync), 0);
    chk("R9 nodet", W'(pat_det), 0);
    while (t < 22) step();
    chk("R9 det", W'(pat_det), 1);
    chk("R9 sync", W'(sync), 1);
    chk("R9 data", data_o, PAT);
    step();
    chk("R5 data", data_o, slice(22, 9));
    while (t < 26) step();
    chk("R6 en high", W'(pat_det), 0);
    chk("R6 offset", data_o, slice(25, 9));
    align_en = 1'b0;
    step();
    align_en = 1'b1;
    step();
    chk("R8 clear2", W'(sync), 0);
    while (t < 30) step();
    chk("R9 off0 det", W'(pat_det), 1);
    chk("R9 off0 data", data_o, PAT);
    step();
    chk("R5 off0 data", data_o, slice(30, 0));
  endtask

  task automatic t_lowest();
    pattern = '1;
    clear_stream();
    for (int p = 8 * W - 5; p < 8 * W + 8; p++) stream[p] = 1'b1;
    do_reset(1'b1);
    for (int c = 0; c < 8; c++) begin
      step();
      chk("R3 en high nodet", W'(pat_det), 0);
    end
    step();
    chk("R4 det", W'(pat_det), 1);
    chk("R4 sync", W'(sync), 1);
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R4 offset", data_o, slice(t - 1, 2));
    end
  endtask

  initial begin
    t_first_lock();
    t_ignore_other();
    t_rearm();
    t_lowest();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule